// File: doc/BRIEF.md
# Baseband Serial Receive Port

This block sits on the MAC side of a link to a baseband demodulator. It drives the demodulator's receive-enable line from a local listen request, and it takes back three lines: a receive clock, a serial data line and a ready strobe. All three are brought into the system clock domain. Data and strobe are sampled when the synchronised receive clock shows a rising edge.

Once the strobe goes high, the first 48 sampled bits form the physical-layer header. The block splits the header into rate, service, length and check fields and presents all four together with a one-cycle valid pulse. Every later group of 8 bits comes out as one payload byte with its own one-cycle valid pulse. The strobe falling marks the end of the packet. A fall before the first payload byte is complete means the demodulator rejected the header. A later fall ends a good packet. The two outcomes are signalled separately, and each has its own saturating counter.

Top module: `bbrx_port`

## Requirements
- R1: `rx_en_o` equals `listen_i` delayed by one system clock. It is 0 in the first cycle after reset.
- R2: `bb_rxd_i` and `bb_ready_i` are sampled only on a rising edge of the synchronised `bb_rxclk_i`. Changes to them while the receive clock is low have no effect.
- R3: The first 48 bits sampled with the strobe high form the header. Each byte arrives least significant bit first. Bits 0–7 are `hdr_rate_o`, bits 8–15 are `hdr_service_o`, bits 16–31 are `hdr_length_o` and bits 32–47 are `hdr_crc_o`. `hdr_valid_o` pulses for one cycle when bit 47 is taken, and the field outputs hold their values until the next header.
- R4: After the header, each 8 sampled bits form one byte on `byte_data_o`, least significant bit first. `byte_valid_o` pulses for one cycle per byte.
- R5: If the strobe is sampled low during the header, or before the first payload byte is complete, `hdr_abort_o` pulses once and `abort_count_o` increments. No `pkt_end_o` is given.
- R6: If the strobe is sampled low after at least one payload byte, `pkt_end_o` pulses once and `good_count_o` increments. A partially received byte is discarded.
- R7: While `rx_en_o` is low, the parse state is held cleared and no valid, end or abort pulse is produced. A packet that starts after re-enabling is parsed from its first bit.
- R8: Both counters are `CNT_W` bits wide and saturate at all ones.
- R9: After reset, all pulse outputs, header fields and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| listen_i | input | 1 | MAC request to receive |
| rx_en_o | output | 1 | Receive enable to the demodulator |
| bb_rxclk_i | input | 1 | Receive clock from the demodulator (asynchronous) |
| bb_rxd_i | input | 1 | Serial receive data |
| bb_ready_i | input | 1 | Ready strobe, high while the demodulator delivers bits |
| hdr_valid_o | output | 1 | One-cycle pulse when the header fields are updated |
| hdr_rate_o | output | 8 | Rate field |
| hdr_service_o | output | 8 | Service field |
| hdr_length_o | output | 16 | Length field |
| hdr_crc_o | output | 16 | Header check field |
| byte_valid_o | output | 1 | One-cycle pulse per payload byte |
| byte_data_o | output | 8 | Payload byte |
| pkt_end_o | output | 1 | One-cycle pulse at the end of a good packet |
| hdr_abort_o | output | 1 | One-cycle pulse when a header is abandoned |
| abort_count_o | output | CNT_W | Saturating count of aborted packets |
| good_count_o | output | CNT_W | Saturating count of completed packets |

## Verification
A wrong bit counter or a wrong state shows at the ports within one packet. The fields come out shifted, bytes are mis-framed, or `hdr_valid_o` arrives at the wrong time. An outcome flag that is not cleared turns the next strobe fall into the wrong pulse, either abort instead of end or the reverse. Parse state that survives a disable shows up as a corrupted header on the very next packet. Data changed while the receive clock is low tests the sampling point directly, and counters checked after each scenario catch a lost or double increment.

// File: rtl/bbrx_pkg.sv
// Package bbrx_pkg: shared constants and the parse state type.
// Assumes a 48-bit header and byte-wide payload.
package bbrx_pkg;
    localparam int HDR_BITS  = 48;
    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/bbrx_sync.sv
// Module bbrx_sync: brings the receive clock, strobe and data into the
// system clock domain through STAGES flops each. It flags the cycle in which
// the synchronised receive clock turns from 0 to 1. All three lines pass
// through the same depth, so the data seen at that edge is the data that was
// present when the receive clock rose.
module bbrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxclk_i,
    input  logic ready_i,
    input  logic rxd_i,
    output logic sample_o,
    output logic ready_o,
    output logic rxd_o
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] stg [STAGES];
    logic            clk_prev;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Purpose: one synchroniser stage for all three lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else if (gi == 0) stg[gi] <= {rxclk_i, ready_i, rxd_i};
                else stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    // Purpose: remember the previous synchronised receive clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= stg[STAGES-1][2];
    end

    assign sample_o = stg[STAGES-1][2] & ~clk_prev;
    assign ready_o  = stg[STAGES-1][1];
    assign rxd_o    = stg[STAGES-1][0];

    AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o); // R2
endmodule

// File: rtl/bbrx_parser.sv
// Module bbrx_parser: turns sampled bits into a header word and payload bytes
// and decides between a good end and an abort when the strobe falls.
// Assumes: sample_i marks one bit; en low clears all parse state.
module bbrx_parser
    import bbrx_pkg::*;
#(
    parameter int HW = HDR_BITS,
    parameter int BW = BYTE_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sample_i,
    input  logic          bit_i,
    input  logic          strobe_i,
    output logic          hdr_valid_o,
    output logic [HW-1:0] hdr_word_o,
    output logic          byte_valid_o,
    output logic [BW-1:0] byte_o,
    output logic          pkt_end_o,
    output logic          abort_o
);
    localparam int          CW       = $clog2(HW + 1);
    localparam logic [CW-1:0] LAST_HDR  = CW'(HW - 1);
    localparam logic [CW-1:0] LAST_BYTE = CW'(BW - 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [HW-1:0] hdr_sr;
    logic [BW-1:0] byte_sr;
    logic          got_byte;

    // Purpose: bit-level parse state machine with single-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            hdr_sr       <= '0;
            byte_sr      <= '0;
            got_byte     <= 1'b0;
            hdr_valid_o  <= 1'b0;
            byte_valid_o <= 1'b0;
            pkt_end_o    <= 1'b0;
            abort_o      <= 1'b0;
            if (!rst_n) begin
                hdr_word_o <= '0;
                byte_o     <= '0;
            end
        end else begin
            hdr_valid_o  <= 1'b0;
            byte_valid_o <= 1'b0;
            pkt_end_o    <= 1'b0;
            abort_o      <= 1'b0;
            if (sample_i) begin
                case (state)
                    ST_IDLE: if (strobe_i) begin
                        hdr_sr <= {bit_i, hdr_sr[HW-1:1]};
                        cnt    <= CW'(1);
                        state  <= ST_HDR;
                    end
                    ST_HDR: if (!strobe_i) begin
                        abort_o <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        hdr_sr <= {bit_i, hdr_sr[HW-1:1]};
                        if (cnt == LAST_HDR) begin
                            hdr_word_o  <= {bit_i, hdr_sr[HW-1:1]};
                            hdr_valid_o <= 1'b1;
                            cnt         <= '0;
                            got_byte    <= 1'b0;
                            state       <= ST_PAY;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_PAY: if (!strobe_i) begin
                        if (got_byte) pkt_end_o <= 1'b1;
                        else          abort_o   <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        byte_sr <= {bit_i, byte_sr[BW-1:1]};
                        if (cnt == LAST_BYTE) begin
                            byte_o       <= {bit_i, byte_sr[BW-1:1]};
                            byte_valid_o <= 1'b1;
                            got_byte     <= 1'b1;
                            cnt          <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_end_o && abort_o)); // R5
    AST_HDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |=> !hdr_valid_o); // R3
    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o); // R4
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(hdr_valid_o || byte_valid_o || pkt_end_o || abort_o)); // R7
endmodule

// File: rtl/bbrx_satcnt.sv
// Module bbrx_satcnt: event counter that stops at all ones.
// Assumes inc_i is a single-cycle pulse per event.
module bbrx_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    // Purpose: count events, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_o <= '0;
        else if (inc_i && ~&cnt_o)   cnt_o <= cnt_o + W'(1);
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_o) |=> (&cnt_o)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !(&cnt_o)) |=> (cnt_o == $past(cnt_o) + W'(1))); // R8
endmodule

// File: rtl/bbrx_port.sv
// Module bbrx_port: MAC-side receive port for a baseband serial stream.
// It drives receive enable, synchronises the incoming lines, parses the
// header and payload, and counts good and aborted packets.
// Assumes the receive clock is much slower than clk (at least 4 clk per phase).
module bbrx_port
    import bbrx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             listen_i,
    output logic             rx_en_o,
    input  logic             bb_rxclk_i,
    input  logic             bb_rxd_i,
    input  logic             bb_ready_i,
    output logic             hdr_valid_o,
    output logic [7:0]       hdr_rate_o,
    output logic [7:0]       hdr_service_o,
    output logic [15:0]      hdr_length_o,
    output logic [15:0]      hdr_crc_o,
    output logic             byte_valid_o,
    output logic [7:0]       byte_data_o,
    output logic             pkt_end_o,
    output logic             hdr_abort_o,
    output logic [CNT_W-1:0] abort_count_o,
    output logic [CNT_W-1:0] good_count_o
);
    logic                sample, ready_s, rxd_s;
    logic [HDR_BITS-1:0] hdr_word;

    // Purpose: register the receive enable sent to the demodulator.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_en_o <= 1'b0;
        else        rx_en_o <= listen_i;
    end

    bbrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxclk_i  (bb_rxclk_i),
        .ready_i  (bb_ready_i),
        .rxd_i    (bb_rxd_i),
        .sample_o (sample),
        .ready_o  (ready_s),
        .rxd_o    (rxd_s)
    );

    bbrx_parser #(.HW(HDR_BITS), .BW(BYTE_BITS)) u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (rx_en_o),
        .sample_i     (sample),
        .bit_i        (rxd_s),
        .strobe_i     (ready_s),
        .hdr_valid_o  (hdr_valid_o),
        .hdr_word_o   (hdr_word),
        .byte_valid_o (byte_valid_o),
        .byte_o       (byte_data_o),
        .pkt_end_o    (pkt_end_o),
        .abort_o      (hdr_abort_o)
    );

    assign hdr_rate_o    = hdr_word[7:0];
    assign hdr_service_o = hdr_word[15:8];
    assign hdr_length_o  = hdr_word[31:16];
    assign hdr_crc_o     = hdr_word[47:32];

    bbrx_satcnt #(.W(CNT_W)) u_abort_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (hdr_abort_o),
        .cnt_o (abort_count_o)
    );

    bbrx_satcnt #(.W(CNT_W)) u_good_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (pkt_end_o),
        .cnt_o (good_count_o)
    );

    AST_RXEN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rx_en_o == $past(listen_i))); // R1
endmodule

// File: tb/bbrx_port_bench.sv
// Directed bench for bbrx_port: one task per scenario, each checking itself.
module bbrx_port_bench;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic listen = 1'b0;
    logic rxclk = 1'b0;
    logic rxd = 1'b0;
    logic rdy = 1'b0;
    logic          rx_en, hdr_valid, byte_valid, pkt_end, hdr_abort;
    logic [7:0]    rate, service, bdata;
    logic [15:0]   length, crc;
    logic [CW-1:0] abort_cnt, good_cnt;

    int n_checks = 0;
    int n_fail = 0;
    int n_hdr = 0, n_byte = 0, n_end = 0, n_abort = 0;
    logic [7:0] seen [0:63];
    logic [7:0] cap_rate, cap_svc;
    logic [15:0] cap_len, cap_crc;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bbrx_port #(.CNT_W(CW)) u_bbrx_port (
        .clk(clk), .rst_n(rst_n), .listen_i(listen), .rx_en_o(rx_en),
        .bb_rxclk_i(rxclk), .bb_rxd_i(rxd), .bb_ready_i(rdy),
        .hdr_valid_o(hdr_valid), .hdr_rate_o(rate), .hdr_service_o(service),
        .hdr_length_o(length), .hdr_crc_o(crc),
        .byte_valid_o(byte_valid), .byte_data_o(bdata),
        .pkt_end_o(pkt_end), .hdr_abort_o(hdr_abort),
        .abort_count_o(abort_cnt), .good_count_o(good_cnt)
    );

    // Monitor of output pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (hdr_valid) begin
            n_hdr++; cap_rate = rate; cap_svc = service; cap_len = length; cap_crc = crc;
        end
        if (byte_valid) begin
            seen[n_byte[5:0]] = bdata; n_byte++;
        end
        if (pkt_end)   n_end++;
        if (hdr_abort) n_abort++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok || act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One serial bit; data is wrong while rxclk is low, then corrected before the rise.
    task automatic send_bit(input bit b, input bit s);
        rxd = ~b; rdy = s; rxclk = 1'b0;
        repeat (2) @(negedge clk);
        rxd = b;
        repeat (2) @(negedge clk);
        rxclk = 1'b1;
        repeat (4) @(negedge clk);
        rxclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i], 1'b1);
    endtask

    task automatic send_header(input logic [7:0] r, input logic [7:0] sv,
                               input logic [15:0] ln, input logic [15:0] c);
        send_byte(r); send_byte(sv);
        send_byte(ln[7:0]); send_byte(ln[15:8]);
        send_byte(c[7:0]); send_byte(c[15:8]);
    endtask

    task automatic drop_strobe();
        send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        check(1'b1, "R9 hdr_valid", int'(hdr_valid), 0);
        check(1'b1, "R9 counters", int'(abort_cnt) + int'(good_cnt), 0);
        check(1'b1, "R9 fields", int'(rate) + int'(length) + int'(bdata), 0);
        check(1'b1, "R1 rx_en after reset", int'(rx_en), 0);
        listen = 1'b1;
        @(negedge clk); @(negedge clk);
        check(1'b1, "R1 rx_en follows listen", int'(rx_en), 1);
    endtask

    task automatic t_good();
        int h = n_hdr, b = n_byte, e = n_end, a = n_abort;
        send_header(8'h0A, 8'h04, 16'h0010, 16'hBEEF);
        send_byte(8'h5A); send_byte(8'hC3); send_byte(8'h01);
        drop_strobe();
        check(1'b1, "R3 header count", n_hdr - h, 1);
        check(1'b1, "R3 rate (R2 glitch-free)", int'(cap_rate), 'h0A);
        check(1'b1, "R3 service", int'(cap_svc), 'h04);
        check(1'b1, "R3 length", int'(cap_len), 'h0010);
        check(1'b1, "R3 crc", int'(cap_crc), 'hBEEF);
        check(1'b1, "R3 field held", int'(length), 'h0010);
        check(1'b1, "R4 byte count", n_byte - b, 3);
        check(1'b1, "R4 byte0", int'(seen[b[5:0]]), 'h5A);
        check(1'b1, "R4 byte1", int'(seen[6'(b+1)]), 'hC3);
        check(1'b1, "R4 byte2", int'(seen[6'(b+2)]), 'h01);
        check(1'b1, "R6 end pulse", n_end - e, 1);
        check(1'b1, "R6 good count", int'(good_cnt), 1);
        check(1'b1, "R5 no abort on good", n_abort - a, 0);
    endtask

    task automatic t_abort_mid();
        int h = n_hdr, e = n_end, a = n_abort;
        for (int i = 0; i < 20; i++) send_bit(i[0], 1'b1);
        drop_strobe();
        check(1'b1, "R5 abort pulse mid header", n_abort - a, 1);
        check(1'b1, "R5 no header", n_hdr - h, 0);
        check(1'b1, "R5 no end", n_end - e, 0);
        check(1'b1, "R5 abort count", int'(abort_cnt), 1);
    endtask

    task automatic t_abort_late();
        int h = n_hdr, b = n_byte, e = n_end, a = n_abort;
        send_header(8'h14, 8'h00, 16'h0100, 16'h1234);
        send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1);
        drop_strobe();
        check(1'b1, "R5 header seen before late abort", n_hdr - h, 1);
        check(1'b1, "R5 late abort pulse", n_abort - a, 1);
        check(1'b1, "R5 late no byte", n_byte - b, 0);
        check(1'b1, "R5 late no end", n_end - e, 0);
        check(1'b1, "R5 abort count 2", int'(abort_cnt), 2);
    endtask

    task automatic t_partial();
        int b = n_byte, e = n_end, a = n_abort;
        send_header(8'h37, 8'h80, 16'h0002, 16'h5555);
        send_byte(8'h96); send_byte(8'h3C);
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
        drop_strobe();
        check(1'b1, "R6 partial: whole bytes only", n_byte - b, 2);
        check(1'b1, "R6 partial byte1", int'(seen[6'(b+1)]), 'h3C);
        check(1'b1, "R6 partial end pulse", n_end - e, 1);
        check(1'b1, "R6 partial no abort", n_abort - a, 0);
        check(1'b1, "R6 good count 2", int'(good_cnt), 2);
    endtask

    task automatic t_disable();
        int h, b, e, a;
        send_byte(8'hFF); send_byte(8'h00);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
        listen = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b1, "R1 rx_en drops", int'(rx_en), 0);
        h = n_hdr; b = n_byte; e = n_end; a = n_abort;
        send_byte(8'hA5); send_byte(8'h0F);
        drop_strobe();
        check(1'b1, "R7 no pulses while off",
              (n_hdr - h) + (n_byte - b) + (n_end - e) + (n_abort - a), 0);
        check(1'b1, "R7 counters unchanged", int'(abort_cnt) * 8 + int'(good_cnt), 2 * 8 + 2);
        listen = 1'b1;
        repeat (3) @(negedge clk);
        send_header(8'h6E, 8'h01, 16'hCAFE, 16'h0F0F);
        send_byte(8'h77);
        drop_strobe();
        check(1'b1, "R7 fresh header rate", int'(cap_rate), 'h6E);
        check(1'b1, "R7 fresh header length", int'(cap_len), 'hCAFE);
        check(1'b1, "R7 fresh payload", int'(seen[6'(n_byte-1)]), 'h77);
        check(1'b1, "R7 good count 3", int'(good_cnt), 3);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 10; k++) begin
            send_bit(1'b1, 1'b1);
            drop_strobe();
        end
        check(1'b1, "R8 abort count saturates", int'(abort_cnt), 7);
        for (int k = 0; k < 5; k++) begin
            send_header(8'h02, 8'h00, 16'h0001, 16'h0000);
            send_byte(8'(k));
            drop_strobe();
        end
        check(1'b1, "R8 good count saturates", int'(good_cnt), 7);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_abort_mid();
        t_abort_late();
        t_partial();
        t_disable();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule